// File: doc/BRIEF.md
# Sixteen-Line GPIO Block with Per-Line Interrupt Detection

This block drives and samples sixteen general-purpose pins through a small synchronous register bus. Each line has a direction bit and an output data bit. Every input passes through a two-flop synchroniser before it can be read back or used to raise an interrupt.

Each line selects one of five detection styles. Two are level styles: pin high and pin low. Three are edge styles: rising, falling, and either edge. A detected event latches a per-line status bit, and that bit drives the line's interrupt output directly. Software clears status bits by writing ones to the status register. A level-style bit stays set for as long as its condition holds. An edge-style bit clears on the write whatever the pin is doing.

A fixed fan-out also places the line interrupts into a 32-bit interrupt-number vector for the system interrupt controller.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the direction register reads 16'hFFFF (every line is an input) and the output data register reads 0. For each line, `pin_oe_n` follows the direction bit: 0 means output and 1 means input. `pin_out` follows the data register. Register addresses: 0 = data, 1 = direction, 2 = input value (read only), 3 = status, 4 = type word for lines 0-7, 5 = type word for lines 8-15.
- R2: The input-value register shows a change on `pin_in` no earlier than two rising clock edges after it is driven, and exactly at the second edge.
- R3: Each line's style is a 3-bit field. Lines 0-7 use type word 4 and lines 8-15 use type word 5. The field sits at bit 3*(line mod 8). Codes: 0 = pin high, 1 = pin low, 2 = rising, 3 = falling, 4 = either edge. Type words read back as written, limited to 24 bits.
- R4: Style codes 5, 6 and 7 behave as pin high.
- R5: A level-style input line sets its status bit while its condition holds. A clear written during that time leaves the bit set. The bit drops only on a clear written after the condition has gone.
- R6: An edge-style input line sets its status bit on its edge. A clear write drops the bit even while the pin stays at its new level.
- R7: Writing 0 to a status bit leaves that bit unchanged. Writes to other registers leave all status bits unchanged.
- R8: A line configured as an output never sets its status bit.
- R9: `irq_line` equals the status register bit for bit.
- R10: `irq_vec` bits 6 and 7 carry lines 0 and 1. Bits 19 to 29 carry lines 2 to 12. All other bits are 0, and lines 13 to 15 are not mapped.
- R11: The either-edge style sets its status bit on both a rising and a falling transition.
- R12: A falling-style line ignores a rising transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| pin_in | input | 16 | Raw asynchronous pin levels |
| pin_out | output | 16 | Output data to the pads |
| pin_oe_n | output | 16 | Per-line output enable, active low |
| irq_line | output | 16 | Per-line interrupt, equal to status |
| irq_vec | output | 32 | Interrupt-number vector |

## Verification
The assertions assume three things. First, a line's style and direction stay put between events. Second, a clear arrives on the bus as a single-cycle write strobe. Third, the pins are sampled only after synchronisation, so any pin change appears as at most one edge per cycle at the detector.

The stimulus respects these assumptions. Every pin pattern is held for at least three clocks, so each change produces exactly one clean edge. Style changes are written while every line is temporarily an output, so a half-updated configuration cannot latch a stray level event. Only after that is the new direction mask applied.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int STYLE_W = 3;

  typedef enum logic [STYLE_W-1:0] {
    STY_HIGH = 3'd0,
    STY_LOW  = 3'd1,
    STY_RISE = 3'd2,
    STY_FALL = 3'd3,
    STY_ANY  = 3'd4
  } style_e;

  localparam logic [2:0] ADR_DATA  = 3'd0;
  localparam logic [2:0] ADR_DIR   = 3'd1;
  localparam logic [2:0] ADR_PINS  = 3'd2;
  localparam logic [2:0] ADR_STAT  = 3'd3;
  localparam logic [2:0] ADR_TYPE0 = 3'd4;

  // Unknown codes fall back to pin-high detection.
  function automatic style_e decode_style(logic [STYLE_W-1:0] raw);
    case (raw)
      3'd1:    return STY_LOW;
      3'd2:    return STY_RISE;
      3'd3:    return STY_FALL;
      3'd4:    return STY_ANY;
      default: return STY_HIGH;
    endcase
  endfunction

  function automatic logic style_is_level(style_e s);
    return (s == STY_HIGH) || (s == STY_LOW);
  endfunction

  // Event condition from the synchronised sample and the one before it.
  function automatic logic style_hit(style_e s, logic cur, logic prev);
    case (s)
      STY_LOW:  return ~cur;
      STY_RISE: return cur & ~prev;
      STY_FALL: return ~cur & prev;
      STY_ANY:  return cur ^ prev;
      default:  return cur;
    endcase
  endfunction

  function automatic int field_lsb(int line, int per_reg, int width);
    return (line % per_reg) * width;
  endfunction

  // Which GPIO line feeds interrupt number 'num'; -1 when none.
  function automatic int irq_source(int num);
    if (num == 6 || num == 7) return num - 6;
    if (num >= 19 && num <= 29) return num - 17;
    return -1;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  logic rst_d1, rst_d2;
  always_ff @(posedge clk) begin
    rst_d1 <= rst_n;
    rst_d2 <= rst_d1;
  end

  p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_d1 && rst_d2) |-> (cur_q == $past(pin_in, 2)));

  p_prev_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_d1 |-> (prev_q == $past(cur_q)));

endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
  import gpio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cur,
  input  logic               prev,
  input  logic               is_input,
  input  logic [STYLE_W-1:0] style_raw,
  input  logic               clr,
  output logic               stat_q,
  output logic               set_evt
);
  style_e sty;
  logic   is_level;
  logic   hit;

  always_comb begin
    sty      = decode_style(style_raw);
    is_level = style_is_level(sty);
    hit      = style_hit(sty, cur, prev);
    set_evt  = is_input & hit;
  end

  // A new event outranks a clear, which is what holds level bits while
  // their condition persists.
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= (stat_q & ~clr) | set_evt;
  end

  p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_input && is_level && hit) |=> stat_q);

  p_edge_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && clr && !set_evt) |=> !stat_q);

  p_keep_on_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr) |=> stat_q);

  p_out_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_input && !stat_q) |=> !stat_q);

  p_any_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_input && sty == STY_ANY && $changed(cur)) |=> stat_q);

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PER_REG   = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  input  logic [NUM_LINES-1:0]         pins_sync,
  input  logic [NUM_LINES-1:0]         stat,
  output logic [NUM_LINES-1:0]         data_q,
  output logic [NUM_LINES-1:0]         dir_q,
  output logic [NUM_LINES*STYLE_W-1:0] style_flat,
  output logic [NUM_LINES-1:0]         clr_mask
);
  localparam int NUM_TREG = NUM_LINES / PER_REG;
  localparam int TREG_W   = PER_REG * STYLE_W;

  logic [TREG_W-1:0] type_q [NUM_TREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADR_DATA)) data_q <= wdata[NUM_LINES-1:0];
      if (addr == ADDR_W'(ADR_DIR))  dir_q  <= wdata[NUM_LINES-1:0];
    end
  end

  for (genvar k = 0; k < NUM_TREG; k++) begin : g_treg
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(int'(ADR_TYPE0) + k);
    always_ff @(posedge clk) begin
      if (!rst_n)                       type_q[k] <= '0;
      else if (wr_en && addr == MY_ADR) type_q[k] <= wdata[TREG_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_field
    localparam int LSB = field_lsb(i, PER_REG, STYLE_W);
    assign style_flat[i*STYLE_W +: STYLE_W] = type_q[i / PER_REG][LSB +: STYLE_W];
  end

  assign clr_mask = (wr_en && addr == ADDR_W'(ADR_STAT)) ? wdata[NUM_LINES-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(ADR_DATA): rdata[NUM_LINES-1:0] = data_q;
      ADDR_W'(ADR_DIR):  rdata[NUM_LINES-1:0] = dir_q;
      ADDR_W'(ADR_PINS): rdata[NUM_LINES-1:0] = pins_sync;
      ADDR_W'(ADR_STAT): rdata[NUM_LINES-1:0] = stat;
      default: begin
        for (int k = 0; k < NUM_TREG; k++)
          if (addr == ADDR_W'(int'(ADR_TYPE0) + k)) rdata[TREG_W-1:0] = type_q[k];
      end
    endcase
  end

  p_dir_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (dir_q == '1 && data_q == '0));

  p_clr_only_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |-> (wr_en && addr == ADDR_W'(ADR_STAT)));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PER_REG   = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int IRQ_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe_n,
  output logic [NUM_LINES-1:0] irq_line,
  output logic [IRQ_W-1:0]     irq_vec
);
  logic [NUM_LINES-1:0]         cur, prev;
  logic [NUM_LINES-1:0]         data_q, dir_q, clr_mask;
  logic [NUM_LINES-1:0]         stat, set_evt;
  logic [NUM_LINES*STYLE_W-1:0] style_flat;

  gpio_in_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur_q(cur), .prev_q(prev)
  );

  gpio_regs #(
    .NUM_LINES(NUM_LINES), .PER_REG(PER_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pins_sync(cur), .stat(stat), .data_q(data_q),
    .dir_q(dir_q), .style_flat(style_flat), .clr_mask(clr_mask)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    gpio_line_detect u_det (
      .clk(clk), .rst_n(rst_n), .cur(cur[i]), .prev(prev[i]),
      .is_input(dir_q[i]), .style_raw(style_flat[i*STYLE_W +: STYLE_W]),
      .clr(clr_mask[i]), .stat_q(stat[i]), .set_evt(set_evt[i])
    );
  end

  assign pin_out  = data_q;
  assign pin_oe_n = dir_q;
  assign irq_line = stat;

  logic [NUM_LINES-1:0] mapped_mask;
  for (genvar b = 0; b < IRQ_W; b++) begin : g_vec
    localparam int SRC = irq_source(b);
    if (SRC >= 0 && SRC < NUM_LINES) begin : g_on
      assign irq_vec[b] = irq_line[SRC];
    end else begin : g_off
      assign irq_vec[b] = 1'b0;
    end
  end

  always_comb begin
    mapped_mask = '0;
    for (int b = 0; b < IRQ_W; b++)
      if (irq_source(b) >= 0 && irq_source(b) < NUM_LINES)
        mapped_mask[irq_source(b)] = 1'b1;
  end

  p_vec_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_vec) == $countones(irq_line & mapped_mask));

  p_set_needs_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_line & ~$past(irq_line)) & ~$past(set_evt)) == '0);

endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [15:0] pin_in = 16'h0;
  logic [15:0] pin_out, pin_oe_n, irq_line;
  logic [31:0] irq_vec;

  int checks = 0;
  int fails = 0;
  logic [15:0] m_pin = 16'h0;
  logic [15:0] m_dir = 16'hFFFF;
  logic [15:0] m_stat = 16'h0;
  int m_sty[16];

  always #10 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n),
    .irq_line(irq_line), .irq_vec(irq_vec)
  );

  function automatic bit lvl_cond(int s, bit v);
    if (s == 1) return !v;
    if (s >= 2 && s <= 4) return 1'b0;
    return v;
  endfunction

  function automatic bit edge_cond(int s, bit o, bit n);
    if (s == 2) return !o && n;
    if (s == 3) return o && !n;
    if (s == 4) return o != n;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_vec(logic [15:0] st);
    logic [31:0] v = 32'h0;
    for (int l = 0; l < 16; l++) begin
      if (l < 2) v[l + 6] = st[l];
      else if (l <= 12) v[l + 17] = st[l];
    end
    return v;
  endfunction

  function automatic logic [15:0] level_now();
    logic [15:0] r = 16'h0;
    for (int l = 0; l < 16; l++) r[l] = m_dir[l] & lvl_cond(m_sty[l], m_pin[l]);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    bus_read(3'd3, d);
    chk({tag, " status"}, d, {16'h0, m_stat});
    chk("R9 irq_line", {16'h0, irq_line}, {16'h0, m_stat});
    chk("R10 irq_vec", irq_vec, exp_vec(m_stat));
  endtask

  task automatic set_pins(logic [15:0] nv);
    logic [31:0] d;
    @(negedge clk);
    pin_in = nv;
    @(negedge clk);
    bus_read(3'd2, d);
    chk("R2 input after one edge", d, {16'h0, m_pin});
    @(negedge clk);
    bus_read(3'd2, d);
    chk("R2 input after two edges", d, {16'h0, nv});
    @(negedge clk);
    for (int l = 0; l < 16; l++)
      if (m_dir[l] && (edge_cond(m_sty[l], m_pin[l], nv[l]) || lvl_cond(m_sty[l], nv[l])))
        m_stat[l] = 1'b1;
    m_pin = nv;
  endtask

  task automatic do_clear(logic [15:0] mask);
    bus_write(3'd3, {16'h0, mask});
    m_stat = (m_stat & ~mask) | level_now();
  endtask

  task automatic configure(logic [15:0] dir);
    logic [31:0] w0 = 32'h0, w1 = 32'h0, d;
    for (int l = 0; l < 16; l++) begin
      if (l < 8) w0 |= 32'(m_sty[l]) << (3 * l);
      else       w1 |= 32'(m_sty[l]) << (3 * (l - 8));
    end
    bus_write(3'd1, 32'h0);
    m_dir = 16'h0;
    bus_write(3'd4, w0);
    bus_write(3'd5, w1);
    bus_read(3'd4, d);
    chk("R3 type word low readback", d, w0 & 32'h00FF_FFFF);
    bus_read(3'd5, d);
    chk("R3 type word high readback", d, w1 & 32'h00FF_FFFF);
    bus_write(3'd1, {16'h0, dir});
    m_dir = dir;
    chk("R1 oe follows dir", {16'h0, pin_oe_n}, {16'h0, dir});
    @(negedge clk);
    m_stat = m_stat | level_now();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    for (int l = 0; l < 16; l++) m_sty[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    bus_read(3'd1, d); chk("R1 dir reset", d, 32'h0000_FFFF);
    bus_read(3'd0, d); chk("R1 data reset", d, 32'h0);
    chk("R1 oe reset", {16'h0, pin_oe_n}, 32'h0000_FFFF);
    check_all("R1 reset");

    bus_write(3'd0, 32'hA5C3);
    chk("R1 pin_out", {16'h0, pin_out}, 32'h0000_A5C3);
    bus_write(3'd2, 32'hFFFF);
    check_all("R7 write to other reg");

    // Directed corner cases.
    for (int l = 0; l < 16; l++) m_sty[l] = 2;
    m_sty[0] = 0; m_sty[1] = 1; m_sty[3] = 3; m_sty[4] = 4;
    m_sty[5] = 6; m_sty[6] = 0; m_sty[9] = 2;
    configure(16'hFFBF);
    chk("R5 low level sets", {16'h0, m_stat}, 32'h0002);
    check_all("R5 low level");
    do_clear(16'h0002);
    check_all("R5 clear while low");
    chk("R5 model held", {16'h0, m_stat}, 32'h0002);

    set_pins(16'h0277);
    chk("R4 R8 R3 event set", {16'h0, m_stat}, 32'h0237);
    check_all("R4 code 6 as high, R8 output quiet, R3 line 9 field");
    do_clear(16'h0000);
    check_all("R7 write zero");
    do_clear(16'h0004);
    chk("R6 edge cleared", {16'h0, m_stat}, 32'h0233);
    check_all("R6 edge clear with pin high");
    do_clear(16'h0001);
    check_all("R5 high held");
    do_clear(16'h0002);
    chk("R5 cleared after condition gone", {16'h0, m_stat}, 32'h0231);
    check_all("R5 cleared");
    do_clear(16'h0010);
    set_pins(16'h0267);
    check_all("R11 falling on either-edge line");
    chk("R11 fall sets", {16'h0, m_stat}, 32'h0231);
    set_pins(16'h026F);
    check_all("R12 rise ignored on falling line");
    set_pins(16'h0267);
    chk("R12 fall sets", {16'h0, m_stat}, 32'h0239);
    check_all("R12 falling line");

    // Random phase.
    for (int b = 0; b < 6; b++) begin
      for (int l = 0; l < 16; l++) m_sty[l] = int'($urandom % 8);
      configure(16'($urandom));
      check_all("R3 R4 random config");
      for (int s = 0; s < 40; s++) begin
        if ($urandom % 10 < 7) set_pins(m_pin ^ 16'($urandom & $urandom));
        else                   do_clear(16'($urandom));
        check_all("R5 R6 R8 random step");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule